// File: doc/BRIEF.md
# Multiprocessor Coherency Unit Register Block

This block is the software-visible register file that sits in front of a multicore coherency controller. It occupies a 256-byte address window and serves single-beat reads and writes of 1, 2 or 4 bytes at any byte offset. It holds three things. The first is a one-bit control register. The second is a read-only configuration word built from the number of processors fitted, a build-time parameter. The third is a 32-bit per-processor power status word that can be read or updated one byte lane at a time. Offsets reserved for address filtering, access control and cache invalidation are decoded, read as zero and ignore writes. The block models none of the coherency, filtering or security behaviour itself.

Requests arrive on a valid/ready channel, and responses leave on a valid/ready channel. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high whenever no response is pending, or when the pending response is being consumed in the same cycle. Each accepted request returns exactly one response in the next cycle. While `rsp_ready` is low, a pending response holds its data unchanged and new requests are refused. Write responses carry zero data.

Top module: `mpc_regblk`

## Requirements
- R1: An accepted request (`req_valid` and `req_ready` high at an edge) raises `rsp_valid` in the next cycle. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` stay unchanged.
- R2: After reset, `rsp_valid` is low, `req_ready` is high, and both the control bit and the power status word read as 0.
- R3: Offset 0x00 is the control register. A write stores only data bit 0, and a read returns that bit in bit 0 with all other bits zero.
- R4: Offset 0x04 reads as `((1<<CPU_COUNT)-1)<<4 | (CPU_COUNT-1)`, which gives 0x10, 0x31, 0x72 and 0xF3 for CPU_COUNT values 1 to 4. Writes to this offset change nothing.
- R5: A read at offset 0x08+k, with k from 0 to 3, returns the status word shifted right by 8*k, with the upper bytes filled with zero. Reads never change any state.
- R6: A write at offset 0x08+k replaces the status bits under `(M << 8*k)` with `(wdata & M) << 8*k`, truncated to 32 bits. M is 0xFF for size 1, 0xFFFF for size 2 and 0xFFFFFFFF for size 4. `req_size` carries the byte count.
- R7: A write whose `req_size` is anything other than 1, 2 or 4 changes no register, but still receives a response.
- R8: Every other offset, including 0x0C, 0x40, 0x44, 0x50 and 0x54, reads as zero and ignores writes.
- R9: A write response returns zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the window |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 are legal) |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Registered read data |

## Verification
Every register's content can be seen in the data of the next read response. A corrupted control bit or status byte therefore shows up one cycle after the read that targets it is accepted. A wrong lane merge is exposed by reading the status word back at all four byte offsets, because each offset shifts a different lane into the low byte. Handshake faults show within the same cycle: `req_ready` stays high while a stalled response is pending, or `rsp_rdata` changes under back-pressure.

// File: rtl/mpc_regblk_pkg.sv
package mpc_regblk_pkg;
  localparam int DATA_W   = 32;
  localparam int LANES    = DATA_W / 8;
  localparam int WIN_SIZE = 256;
  localparam int ADDR_W   = $clog2(WIN_SIZE);
  localparam int SIZE_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_CTRL = 8'h00,
    OFS_CFG  = 8'h04,
    OFS_PWR  = 8'h08
  } reg_ofs_e;

  // Byte-enable pattern (relative to the addressed lane) for a given size;
  // zero for an illegal size.
  function automatic logic [LANES-1:0] size_lanes(input logic [SIZE_W-1:0] sz);
    case (sz)
      3'd1:    return 4'b0001;
      3'd2:    return 4'b0011;
      3'd4:    return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/mpc_bus_port.sv
module mpc_bus_port
  import mpc_regblk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              accept,
  input  logic [DATA_W-1:0] rd_value,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_value;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mpc_cfg_gen.sv
module mpc_cfg_gen
  import mpc_regblk_pkg::*;
#(
  parameter int CPU_COUNT = 1
) (
  output logic [DATA_W-1:0] cfg_value
);
  localparam int MAX_CPU = 4;

  if (CPU_COUNT < 1 || CPU_COUNT > MAX_CPU) begin : g_bad_count
    $error("mpc_cfg_gen: CPU_COUNT must be 1..4");
  end

  logic [MAX_CPU-1:0] present;
  for (genvar c = 0; c < MAX_CPU; c++) begin : g_cpu
    assign present[c] = (c < CPU_COUNT);
  end

  localparam logic [1:0] LAST_ID = 2'(CPU_COUNT - 1);
  assign cfg_value = {{(DATA_W-8){1'b0}}, present, 2'b00, LAST_ID};
endmodule

// File: rtl/mpc_pwr_word.sv
module mpc_pwr_word
  import mpc_regblk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        lane_sel,
  input  logic [LANES-1:0]  rel_lanes,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word_q
);
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic       hit;
    logic [7:0] nxt;
    always_comb begin
      hit = 1'b0;
      nxt = word_q[8*b +: 8];
      for (int s = 0; s <= b; s++) begin
        if (lane_sel == 2'(s) && rel_lanes[b-s]) begin
          hit = 1'b1;
          nxt = wdata[8*(b-s) +: 8];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)            word_q[8*b +: 8] <= 8'h00;
      else if (wr_en && hit) word_q[8*b +: 8] <= nxt;
    end
  end
endmodule

// File: rtl/mpc_regblk.sv
module mpc_regblk
  import mpc_regblk_pkg::*;
#(
  parameter int CPU_COUNT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic              accept;
  logic [DATA_W-1:0] rd_value;
  logic [DATA_W-1:0] cfg_value;
  logic [DATA_W-1:0] pwr_q;
  logic [LANES-1:0]  rel_lanes;
  logic              wr_ok;
  logic              hit_ctrl;
  logic              hit_pwr;
  logic              ctrl_q;

  assign rel_lanes = size_lanes(req_size);
  assign wr_ok     = accept && req_write && (rel_lanes != '0);
  assign hit_ctrl  = (req_addr == OFS_CTRL);
  assign hit_pwr   = (req_addr[ADDR_W-1:2] == OFS_PWR[ADDR_W-1:2]);

  mpc_bus_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .rd_value  (rd_value),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata)
  );

  mpc_cfg_gen #(.CPU_COUNT(CPU_COUNT)) u_cfg (
    .cfg_value (cfg_value)
  );

  mpc_pwr_word u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_ok && hit_pwr),
    .lane_sel  (req_addr[1:0]),
    .rel_lanes (rel_lanes),
    .wdata     (req_wdata),
    .word_q    (pwr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                 ctrl_q <= 1'b0;
    else if (wr_ok && hit_ctrl) ctrl_q <= req_wdata[0];
  end

  always_comb begin
    rd_value = '0;
    if (!req_write) begin
      if (hit_ctrl)                 rd_value = {{(DATA_W-1){1'b0}}, ctrl_q};
      else if (req_addr == OFS_CFG) rd_value = cfg_value;
      else if (hit_pwr)             rd_value = pwr_q >> {req_addr[1:0], 3'b000};
    end
  end
endmodule

// File: rtl/mpc_regblk_chk.sv
module mpc_regblk_chk
  import mpc_regblk_pkg::*;
#(
  parameter int CPU_COUNT = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata
);
  function automatic logic [DATA_W-1:0] cfg_expect();
    logic [DATA_W-1:0] v;
    v = DATA_W'(CPU_COUNT - 1);
    for (int i = 0; i < CPU_COUNT; i++) v[4+i] = 1'b1;
    return v;
  endfunction

  logic acc;
  assign acc = req_valid && req_ready;

  a_r1_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  a_r1_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  a_r1_refuse_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  a_r3_ctrl_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_addr == 8'h00) |=> (rsp_rdata[DATA_W-1:1] == '0));
  a_r4_cfg_value: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_addr == 8'h04) |=> (rsp_rdata == cfg_expect()));
  a_r5_top_lane_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_addr == 8'h0B) |=> (rsp_rdata[DATA_W-1:8] == '0));
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && (req_addr == 8'h0C || req_addr == 8'h40 || req_addr == 8'h44
      || req_addr == 8'h50 || req_addr == 8'h54)) |=> (rsp_rdata == '0));
  a_r9_write_rsp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> (rsp_rdata == '0));
endmodule

bind mpc_regblk mpc_regblk_chk #(.CPU_COUNT(CPU_COUNT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata)
);

// File: tb/mpc_regblk_test.sv
`timescale 1ns/1ps
module mpc_regblk_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] pwr_model = '0;

  always #4 clk = ~clk;

  mpc_regblk uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata)
  );

  logic [31:0] alt_rdata [2:4];
  for (genvar n = 2; n <= 4; n++) begin : g_alt
    logic alt_rdy, alt_vld;
    mpc_regblk #(.CPU_COUNT(n)) u_alt (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(alt_rdy),
      .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
      .req_wdata(req_wdata), .rsp_valid(alt_vld), .rsp_ready(rsp_ready),
      .rsp_rdata(alt_rdata[n])
    );
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [7:0] a, input logic [2:0] sz,
                      input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 rsp_valid after accept", {31'b0, rsp_valid}, 32'd1);
    rd = rsp_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] r;
    xfer(1'b0, a, 3'd4, 32'h0, r);
    check(tag, r, exp);
  endtask

  task automatic pwr_wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
    logic [31:0] r, m;
    int sh;
    xfer(1'b1, a, sz, d, r);
    check("R9 write response data", r, 32'h0);
    m = (sz == 3'd1) ? 32'hFF : (sz == 3'd2) ? 32'hFFFF : (sz == 3'd4) ? 32'hFFFFFFFF : 32'h0;
    sh = 8 * (a - 8'h08);
    pwr_model = (pwr_model & ~(m << sh)) | ((d & m) << sh);
  endtask

  task automatic pwr_readback(input string tag);
    for (int k = 0; k < 4; k++) rd_chk(tag, 8'h08 + 8'(k), pwr_model >> (8 * k));
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R2 rsp_valid low", {31'b0, rsp_valid}, 32'd0);
    check("R2 req_ready high", {31'b0, req_ready}, 32'd1);
    rd_chk("R2 control reset", 8'h00, 32'h0);
    rd_chk("R2 power reset", 8'h08, 32'h0);
  endtask

  task automatic t_control;
    logic [31:0] r;
    xfer(1'b1, 8'h00, 3'd4, 32'hFFFFFFFF, r);
    rd_chk("R3 control set", 8'h00, 32'h1);
    xfer(1'b1, 8'h00, 3'd4, 32'hFFFFFFFE, r);
    rd_chk("R3 control clear", 8'h00, 32'h0);
    xfer(1'b1, 8'h00, 3'd1, 32'h00000003, r);
    rd_chk("R3 control byte write", 8'h00, 32'h1);
  endtask

  task automatic t_config;
    logic [31:0] r;
    xfer(1'b1, 8'h04, 3'd4, 32'hFFFFFFFF, r);
    xfer(1'b0, 8'h04, 3'd4, 32'h0, r);
    check("R4 config N=1", r, 32'h10);
    check("R4 config N=2", alt_rdata[2], 32'h31);
    check("R4 config N=3", alt_rdata[3], 32'h72);
    check("R4 config N=4", alt_rdata[4], 32'hF3);
  endtask

  task automatic t_power;
    pwr_wr(8'h08, 3'd4, 32'h11223344);
    pwr_readback("R5 full word read at each offset");
    for (int k = 0; k < 4; k++) pwr_wr(8'h08 + 8'(k), 3'd1, 32'hDEADBE00 | (32'hA0 + k));
    pwr_readback("R6 byte write at each lane");
    pwr_wr(8'h09, 3'd2, 32'h5555CAFE);
    pwr_readback("R6 halfword at odd offset");
    pwr_wr(8'h0B, 3'd2, 32'h00007788);
    pwr_readback("R6 halfword past top discarded");
    pwr_wr(8'h0A, 3'd4, 32'h99AABBCC);
    pwr_readback("R6 word at offset 2 truncated");
  endtask

  task automatic t_bad_size;
    logic [31:0] r;
    xfer(1'b1, 8'h08, 3'd3, 32'h0BADF00D, r);
    xfer(1'b1, 8'h09, 3'd0, 32'h0BADF00D, r);
    xfer(1'b1, 8'h08, 3'd7, 32'h0BADF00D, r);
    xfer(1'b1, 8'h00, 3'd5, 32'h00000000, r);
    pwr_readback("R7 illegal size write dropped");
    rd_chk("R7 control unchanged by illegal size", 8'h00, 32'h1);
  endtask

  task automatic t_reserved;
    logic [31:0] r;
    logic [7:0] ofs [8] = '{8'h0C, 8'h40, 8'h44, 8'h50, 8'h54, 8'h10, 8'hFF, 8'h01};
    for (int i = 0; i < 8; i++) xfer(1'b1, ofs[i], 3'd4, 32'hFFFFFFFF, r);
    for (int i = 0; i < 8; i++) rd_chk("R8 reserved reads zero", ofs[i], 32'h0);
    pwr_readback("R8 power unchanged by reserved writes");
    rd_chk("R8 control unchanged by reserved writes", 8'h00, 32'h1);
  endtask

  task automatic t_backpressure;
    logic [31:0] held;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h08; req_size = 3'd4;
    @(negedge clk);
    req_valid = 1'b0;
    held = rsp_rdata;
    check("R1 stalled response data", held, pwr_model);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 rsp_valid held", {31'b0, rsp_valid}, 32'd1);
      check("R1 req_ready low while stalled", {31'b0, req_ready}, 32'd0);
      check("R1 rsp_rdata stable", rsp_rdata, held);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R1 response drained", {31'b0, rsp_valid}, 32'd0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_control();
    t_config();
    t_power();
    t_bad_size();
    t_reserved();
    t_backpressure();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule